// File: doc/BRIEF.md
# Load Value Predictor with Classifier

This block guesses the data a load will return before the load reaches memory. A table indexed by the load's PC holds the last value each load produced, and a second table indexed the same way holds a small saturating confidence counter per entry. At fetch, a lookup by PC returns the stored value together with a class. The class is one of three: do not use the guess, use the guess, or treat the load as constant.

When a load completes, its PC, data address and real value arrive on the resolve port. The counter moves up when the stored value matched and down when it did not. On a miss the stored value is replaced in the same clock edge. A load that is already constant and is guessed right again has its data address recorded in a small fully associative constant table.

In the execute stage, a query with the load's PC and data address reports whether the load may skip cache verification. Any store to a recorded address removes that entry. A constant-class load whose address is no longer recorded must then be verified as usual. A parameter selects a one-bit counter in place of the two-bit one.

Top module: `lvp_top`

## Requirements
- R1: Both tables are untagged and direct-mapped. The entry is PC bits [IDX_W+1:2], so two PCs that differ only outside those bits share one value and one counter.
- R2: The lookup returns, combinationally, the last value written to the entry. A resolve becomes visible at the lookup one cycle after it is presented.
- R3: With CTR_W=2 the counter rises by one when the resolved value equals the stored value and falls by one otherwise. It saturates at 0 and at 3.
- R4: lkClass encodes 0 = do not predict, 1 = predictable, 2 = constant. With CTR_W=2, counter 0 or 1 gives 0, counter 2 gives 1 and counter 3 gives 2. The value 3 never appears.
- R5: With CTR_W=1 the counter saturates at 0 and 1. Counter 0 gives class 0 and counter 1 gives class 2.
- R6: On a resolve whose value differs from the stored one, the value entry is overwritten with the actual value at the same edge the counter falls. Every constant-table entry holding that index is invalidated.
- R7: A resolve that matches while its counter is already at the top fills the constant table with (rsAddr, index). An entry with the same address is rewritten in place. Otherwise the lowest-numbered free slot is used. When all CVU_N slots are valid, a replacement slot is used that starts at 0 and advances by one (wrapping) on each such replacement.
- R8: vqSkip is 1 exactly when the class for vqPc is constant and a valid constant-table entry holds address vqAddr with the index of vqPc.
- R9: A store invalidates every constant-table entry with address stAddr, and vqSkip drops from the next cycle. A store in the same cycle as a fill to the same address cancels that fill.
- R10: After reset all values and counters are 0 and the constant table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkPc | input | PC_W | Fetch lookup PC |
| lkValue | output | DATA_W | Predicted load value |
| lkClass | output | 2 | Prediction class (R4 encoding) |
| rsValid | input | 1 | Resolve strobe |
| rsPc | input | PC_W | PC of the resolving load |
| rsAddr | input | ADDR_W | Data address of the resolving load |
| rsValue | input | DATA_W | Actual loaded value |
| stValid | input | 1 | Store snoop strobe |
| stAddr | input | ADDR_W | Store data address |
| vqPc | input | PC_W | Verify-query load PC |
| vqAddr | input | ADDR_W | Verify-query data address |
| vqSkip | output | 1 | Load may skip cache verification |

## Verification
A counter that drifts shows up on lkClass at the very next lookup of that entry. A value entry that is not rewritten after a miss shows up on lkValue in the cycle that follows the resolve. A constant-table entry that survives a store, or survives a miss on its index, raises vqSkip one cycle after that event. That makes a stale constant visible before any load could consume it. A wrong replacement choice only appears after the table is full, so the bench fills it past capacity and probes the evicted and surviving addresses.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_PRED  = 2'd1,
    CLS_CONST = 2'd2
  } lvpClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incCtr;
    logic decCtr;
    logic writeVal;
    logic fillCvu;
    logic killIdx;
    logic killAddr;
  } lvpStrobe_t;

  function automatic lvpClass_e ctrToClass(input logic [1:0] ctr, input int ctrW);
    if (ctrW == 1) return ctr[0] ? CLS_CONST : CLS_NONE;
    case (ctr)
      2'd2:    return CLS_PRED;
      2'd3:    return CLS_CONST;
      default: return CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lvp_ctrl.sv
module lvp_ctrl
  import lvp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CTR_W  = 2
) (
  input  logic              rsValid,
  input  logic [DATA_W-1:0] rsValue,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [DATA_W-1:0] rsOldValue,
  input  logic [1:0]        rsOldCtr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  output lvpStrobe_t        strobe
);
  localparam logic [1:0] CTR_TOP = 2'((1 << CTR_W) - 1);

  logic hitGuess;
  logic fillBlocked;

  always_comb begin
    hitGuess    = (rsOldValue == rsValue);
    fillBlocked = stValid && (stAddr == rsAddr);
    strobe.incCtr   = rsValid && hitGuess && (rsOldCtr != CTR_TOP);
    strobe.decCtr   = rsValid && !hitGuess && (rsOldCtr != 2'd0);
    strobe.writeVal = rsValid && !hitGuess;
    strobe.killIdx  = rsValid && !hitGuess;
    strobe.fillCvu  = rsValid && hitGuess && (rsOldCtr == CTR_TOP) && !fillBlocked;
    strobe.killAddr = stValid;
  end

endmodule

// File: rtl/lvp_data.sv
module lvp_data
  import lvp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2,
  parameter int CVU_N  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lvpStrobe_t        strobe,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [PC_W-1:0]   rsPc,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [DATA_W-1:0] rsValue,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [PC_W-1:0]   vqPc,
  input  logic [ADDR_W-1:0] vqAddr,
  output logic [DATA_W-1:0] lkValue,
  output logic [1:0]        lkCtr,
  output logic [DATA_W-1:0] rsOldValue,
  output logic [1:0]        rsOldCtr,
  output logic [1:0]        vqCtr,
  output logic              vqHit
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CVU_W = (CVU_N > 1) ? $clog2(CVU_N) : 1;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [DATA_W-1:0] valTbl [DEPTH];
  logic [CTR_W-1:0]  ctrTbl [DEPTH];
  logic [CVU_N-1:0]  cvuValid;
  logic [ADDR_W-1:0] cvuAddr [CVU_N];
  logic [IDX_W-1:0]  cvuIdx  [CVU_N];
  logic [CVU_W-1:0]  rrPtr;

  logic [IDX_W-1:0] lkIdx, rsIdx, vqIdx;
  logic [CVU_N-1:0] vqMatch, vqFull;
  logic [CVU_W-1:0] fillSlot;
  logic             useRr;

  assign lkIdx = lkPc[IDX_W+1:2];
  assign rsIdx = rsPc[IDX_W+1:2];
  assign vqIdx = vqPc[IDX_W+1:2];

  logic unusedPcBits;
  assign unusedPcBits = ^{lkPc[1:0], rsPc[1:0], vqPc[1:0],
                          lkPc[PC_W-1:IDX_W+2], rsPc[PC_W-1:IDX_W+2], vqPc[PC_W-1:IDX_W+2]};

  assign lkValue    = valTbl[lkIdx];
  assign lkCtr      = 2'(ctrTbl[lkIdx]);
  assign rsOldValue = valTbl[rsIdx];
  assign rsOldCtr   = 2'(ctrTbl[rsIdx]);
  assign vqCtr      = 2'(ctrTbl[vqIdx]);

  for (genvar g = 0; g < CVU_N; g++) begin : g_match
    assign vqMatch[g] = cvuValid[g] && (cvuAddr[g] == vqAddr);
    assign vqFull[g]  = vqMatch[g] && (cvuIdx[g] == vqIdx);
  end
  assign vqHit = |vqFull;

  // slot choice: same address, else lowest free, else round robin
  always_comb begin
    logic found;
    found    = 1'b0;
    fillSlot = '0;
    useRr    = 1'b0;
    for (int i = 0; i < CVU_N; i++) begin
      if (!found && cvuValid[i] && (cvuAddr[i] == rsAddr)) begin
        fillSlot = CVU_W'(i);
        found    = 1'b1;
      end
    end
    for (int i = 0; i < CVU_N; i++) begin
      if (!found && !cvuValid[i]) begin
        fillSlot = CVU_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      fillSlot = rrPtr;
      useRr    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        valTbl[i] <= '0;
        ctrTbl[i] <= '0;
      end
      for (int i = 0; i < CVU_N; i++) begin
        cvuAddr[i] <= '0;
        cvuIdx[i]  <= '0;
      end
      cvuValid <= '0;
      rrPtr    <= '0;
    end else begin
      if (strobe.writeVal) valTbl[rsIdx] <= rsValue;
      if (strobe.incCtr)   ctrTbl[rsIdx] <= ctrTbl[rsIdx] + 1'b1;
      if (strobe.decCtr)   ctrTbl[rsIdx] <= ctrTbl[rsIdx] - 1'b1;
      for (int i = 0; i < CVU_N; i++) begin
        if (strobe.killAddr && cvuAddr[i] == stAddr) cvuValid[i] <= 1'b0;
        if (strobe.killIdx && cvuIdx[i] == rsIdx)    cvuValid[i] <= 1'b0;
      end
      if (strobe.fillCvu) begin
        cvuValid[fillSlot] <= 1'b1;
        cvuAddr[fillSlot]  <= rsAddr;
        cvuIdx[fillSlot]   <= rsIdx;
        if (useRr) rrPtr <= (rrPtr == CVU_W'(CVU_N - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

  // assertion support: address of the last store
  logic [ADDR_W-1:0] stAddrQ;
  logic              stHeld;
  always_ff @(posedge clk) stAddrQ <= stAddr;
  always_comb begin
    stHeld = 1'b0;
    for (int i = 0; i < CVU_N; i++)
      if (cvuValid[i] && cvuAddr[i] == stAddrQ) stHeld = 1'b1;
  end

  // R9
  store_revoke_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killAddr |=> !stHeld);

  // R6
  mispredict_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeVal |=> valTbl[$past(rsIdx)] == $past(rsValue));

  // R3
  ctr_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCtr |=> ctrTbl[$past(rsIdx)] == CTR_W'($past(ctrTbl[rsIdx]) - 1'b1));

  // R7
  cvu_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vqMatch));

  // R3
  ctr_top_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillCvu && !strobe.killAddr) |=> ctrTbl[$past(rsIdx)] == CTR_MAX);

endmodule

// File: rtl/lvp_top.sv
module lvp_top
  import lvp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2,
  parameter int CVU_N  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lkPc,
  output logic [DATA_W-1:0] lkValue,
  output logic [1:0]        lkClass,
  input  logic              rsValid,
  input  logic [PC_W-1:0]   rsPc,
  input  logic [ADDR_W-1:0] rsAddr,
  input  logic [DATA_W-1:0] rsValue,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [PC_W-1:0]   vqPc,
  input  logic [ADDR_W-1:0] vqAddr,
  output logic              vqSkip
);
  lvpStrobe_t        strobe;
  logic [DATA_W-1:0] rsOldValue;
  logic [1:0]        rsOldCtr, lkCtr, vqCtr;
  logic              vqHit;

  lvp_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTR_W(CTR_W)) u_ctrl (
    .rsValid(rsValid), .rsValue(rsValue), .rsAddr(rsAddr),
    .rsOldValue(rsOldValue), .rsOldCtr(rsOldCtr),
    .stValid(stValid), .stAddr(stAddr), .strobe(strobe)
  );

  lvp_data #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
             .CTR_W(CTR_W), .CVU_N(CVU_N)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkPc(lkPc), .rsPc(rsPc), .rsAddr(rsAddr), .rsValue(rsValue),
    .stAddr(stAddr), .vqPc(vqPc), .vqAddr(vqAddr),
    .lkValue(lkValue), .lkCtr(lkCtr), .rsOldValue(rsOldValue),
    .rsOldCtr(rsOldCtr), .vqCtr(vqCtr), .vqHit(vqHit)
  );

  assign lkClass = ctrToClass(lkCtr, CTR_W);
  assign vqSkip  = vqHit && (ctrToClass(vqCtr, CTR_W) == CLS_CONST);

  // R4
  class_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkClass != 2'd3);

endmodule

// File: tb/sim_lvp_top.sv
module sim_lvp_top;
  localparam int NV = 2;
  localparam int DEPTH = 64;
  localparam int SLOTS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] lkPc = 0, rsPc = 0, rsAddr = 0, rsValue = 0, stAddr = 0, vqPc = 0, vqAddr = 0;
  logic        rsValid = 0, stValid = 0;
  logic [31:0] lkValue0, lkValue1;
  logic [1:0]  lkClass0, lkClass1;
  logic        vqSkip0, vqSkip1;

  lvp_top #(.CTR_W(2)) u0 (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkValue(lkValue0), .lkClass(lkClass0),
    .rsValid(rsValid), .rsPc(rsPc), .rsAddr(rsAddr), .rsValue(rsValue),
    .stValid(stValid), .stAddr(stAddr), .vqPc(vqPc), .vqAddr(vqAddr), .vqSkip(vqSkip0));

  lvp_top #(.CTR_W(1)) u1 (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkValue(lkValue1), .lkClass(lkClass1),
    .rsValid(rsValid), .rsPc(rsPc), .rsAddr(rsAddr), .rsValue(rsValue),
    .stValid(stValid), .stAddr(stAddr), .vqPc(vqPc), .vqAddr(vqAddr), .vqSkip(vqSkip1));

  // behavioural reference, variant 0 = two-bit, variant 1 = one-bit
  int unsigned mVal [NV][DEPTH];
  int          mCtr [NV][DEPTH];
  bit          cV   [NV][SLOTS];
  int unsigned cA   [NV][SLOTS];
  int          cI   [NV][SLOTS];
  int          rr   [NV];
  int nChk = 0, nFail = 0;
  bit done = 0;

  function automatic int idxOf(input logic [31:0] pc);
    return int'((pc >> 2) & 32'(DEPTH - 1));
  endfunction

  function automatic int topOf(input int v);
    return (v == 0) ? 3 : 1;
  endfunction

  function automatic int clsOf(input int v, input int ctr);
    if (v == 1) return (ctr == 1) ? 2 : 0;
    if (ctr == 3) return 2;
    if (ctr == 2) return 1;
    return 0;
  endfunction

  function automatic int skipOf(input int v, input logic [31:0] pc, input logic [31:0] addr);
    int i = idxOf(pc);
    if (clsOf(v, mCtr[v][i]) != 2) return 0;
    for (int s = 0; s < SLOTS; s++)
      if (cV[v][s] && cA[v][s] == addr && cI[v][s] == i) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < DEPTH; i++) begin mVal[v][i] = 0; mCtr[v][i] = 0; end
      for (int s = 0; s < SLOTS; s++) begin cV[v][s] = 0; cA[v][s] = 0; cI[v][s] = 0; end
      rr[v] = 0;
    end
  endtask

  task automatic modelStep();
    for (int v = 0; v < NV; v++) begin
      int i = idxOf(rsPc);
      bit corr = (mVal[v][i] == rsValue);
      bit fill = rsValid && corr && (mCtr[v][i] == topOf(v)) && !(stValid && stAddr == rsAddr);
      int slot = -1;
      bit wrap = 0;
      for (int s = 0; s < SLOTS; s++) if (slot < 0 && cV[v][s] && cA[v][s] == rsAddr) slot = s;
      for (int s = 0; s < SLOTS; s++) if (slot < 0 && !cV[v][s]) slot = s;
      if (slot < 0) begin slot = rr[v]; wrap = 1; end
      if (rsValid) begin
        if (corr) begin
          if (mCtr[v][i] < topOf(v)) mCtr[v][i]++;
        end else begin
          if (mCtr[v][i] > 0) mCtr[v][i]--;
          mVal[v][i] = rsValue;
          for (int s = 0; s < SLOTS; s++) if (cI[v][s] == i) cV[v][s] = 0;
        end
      end
      if (stValid)
        for (int s = 0; s < SLOTS; s++) if (cA[v][s] == stAddr) cV[v][s] = 0;
      if (fill) begin
        cV[v][slot] = 1; cA[v][slot] = rsAddr; cI[v][slot] = i;
        if (wrap) rr[v] = (rr[v] + 1) % SLOTS;
      end
    end
  endtask

  task automatic cmpAll();
    chk("R2", "u0 lkValue", lkValue0, mVal[0][idxOf(lkPc)]);
    chk("R4", "u0 lkClass", lkClass0, clsOf(0, mCtr[0][idxOf(lkPc)]));
    chk("R8", "u0 vqSkip", vqSkip0, skipOf(0, vqPc, vqAddr));
    chk("R2", "u1 lkValue", lkValue1, mVal[1][idxOf(lkPc)]);
    chk("R5", "u1 lkClass", lkClass1, clsOf(1, mCtr[1][idxOf(lkPc)]));
    chk("R8", "u1 vqSkip", vqSkip1, skipOf(1, vqPc, vqAddr));
  endtask

  // drive at negedge, compare, then advance the model for the coming edge
  task automatic tick(input bit rv, input logic [31:0] rp, input logic [31:0] ra, input logic [31:0] rval,
                      input bit sv, input logic [31:0] sa, input logic [31:0] lp,
                      input logic [31:0] qp, input logic [31:0] qa);
    @(negedge clk);
    rsValid = rv; rsPc = rp; rsAddr = ra; rsValue = rval;
    stValid = sv; stAddr = sa; lkPc = lp; vqPc = qp; vqAddr = qa;
    #1;
    cmpAll();
    modelStep();
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] val);
    tick(1, pc, addr, val, 0, 0, pc, pc, addr);
  endtask

  task automatic probe(input logic [31:0] pc, input logic [31:0] addr);
    tick(0, 0, 0, 0, 0, 0, pc, pc, addr);
  endtask

  localparam logic [31:0] PA = 32'h40;

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    lkPc = PA; vqPc = PA; vqAddr = 32'h1000;
    #1;
    chk("R10", "reset lkValue", lkValue0, 0);
    chk("R10", "reset lkClass", lkClass0, 0);
    chk("R10", "reset vqSkip", vqSkip0, 0);
    rstN = 1'b1;

    train(PA, 32'h1000, 32'hAB);          // miss: value 0 != AB
    probe(PA, 32'h1000);
    chk("R6", "value after miss", lkValue0, 32'hAB);
    chk("R3", "class after miss at 0", lkClass0, 0);
    train(PA, 32'h1000, 32'hAB);          // u0 ctr 1, u1 ctr 1
    probe(PA, 32'h1000);
    chk("R4", "ctr1 class", lkClass0, 0);
    chk("R5", "one-bit constant", lkClass1, 2);
    train(PA, 32'h1000, 32'hAB);          // ctr 2
    probe(PA, 32'h1000);
    chk("R4", "ctr2 class", lkClass0, 1);
    train(PA, 32'h1000, 32'hAB);          // ctr 3
    probe(PA, 32'h1000);
    chk("R4", "ctr3 class", lkClass0, 2);
    chk("R8", "constant but not recorded", vqSkip0, 0);
    train(PA, 32'h1000, 32'hAB);          // fill slot 0
    probe(PA, 32'h1000);
    chk("R3", "saturated class", lkClass0, 2);
    chk("R8", "skip after fill", vqSkip0, 1);
    probe(PA, 32'h1004);
    chk("R8", "other address", vqSkip0, 0);
    probe(PA + 32'h100, 32'h1000);
    chk("R1", "alias lkValue", lkValue0, 32'hAB);
    chk("R1", "alias skip", vqSkip0, 1);

    tick(0, 0, 0, 0, 1, 32'h1000, PA, PA, 32'h1000);
    probe(PA, 32'h1000);
    chk("R9", "skip after store", vqSkip0, 0);
    chk("R9", "class kept after store", lkClass0, 2);
    train(PA, 32'h1000, 32'hAB);          // refill slot 0
    probe(PA, 32'h1000);
    chk("R9", "refill after store", vqSkip0, 1);

    for (int k = 1; k < SLOTS; k++) train(PA, 32'h2000 + 32'(k * 4), 32'hAB);
    train(PA, 32'h3000, 32'hAB);          // full: replaces slot 0
    probe(PA, 32'h1000);
    chk("R7", "evicted slot 0", vqSkip0, 0);
    probe(PA, 32'h3000);
    chk("R7", "new entry", vqSkip0, 1);
    probe(PA, 32'h2004);
    chk("R7", "slot 1 kept", vqSkip0, 1);
    train(PA, 32'h2008, 32'hAB);          // same address rewritten in place
    train(PA, 32'h3004, 32'hAB);          // replaces slot 1
    probe(PA, 32'h2004);
    chk("R7", "second replacement", vqSkip0, 0);
    probe(PA, 32'h2008);
    chk("R7", "in-place kept", vqSkip0, 1);

    tick(1, PA, 32'h4000, 32'hAB, 1, 32'h4000, PA, PA, 32'h4000);
    probe(PA, 32'h4000);
    chk("R9", "fill cancelled by store", vqSkip0, 0);

    train(PA, 32'h3000, 32'h55);          // mispredict
    probe(PA, 32'h3000);
    chk("R6", "value rewritten", lkValue0, 32'h55);
    chk("R6", "class after miss", lkClass0, 1);
    chk("R6", "index entries dropped", vqSkip0, 0);
    chk("R5", "one-bit drop", lkClass1, 0);

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] p, a, val, sp, sa2, lp, qp, qa;
      p   = 32'((($urandom % 12) * 4) + (($urandom % 4 == 0) ? 32'h100 : 0));
      a   = 32'h8000 + 32'(($urandom % 14) * 4);
      val = ($urandom % 8 == 0) ? 32'($urandom % 4) : p * 3;
      sa2 = 32'h8000 + 32'(($urandom % 14) * 4);
      lp  = 32'(($urandom % 12) * 4);
      qp  = ($urandom % 2 == 0) ? p : lp;
      qa  = ($urandom % 2 == 0) ? a : sa2;
      sp  = 32'($urandom % 10);
      tick($urandom % 10 < 6, p, a, val, sp == 0, sa2, lp, qp, qa);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule